// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The walker follows a chain of command blocks stored in a word-wide memory and passes each block's payload to a downstream command sink. Every node starts with a 32-bit header whose top byte is a payload word count and whose low 24 bits link to the next node. The payload words sit at the word addresses just after the header. A pulse on `start` with a link value begins the walk. The block reads the header, streams the payload out on a valid/ready port, and moves to the next node. It stops at a sentinel link or when it meets a node it has already visited.

To catch circular chains, each header is tagged as it is read by setting bit 23 of its link field in memory. When a later header is read with that bit already set, the walk ends and reports a loop. After the walk, a cleanup pass starts again from the start link and follows the same number of tagged nodes. It clears the tag in each one, so memory ends up as it was. The memory port has a one-cycle synchronous read: `mem_rdata` is valid in the cycle after `mem_rd`.

Top module: `chain_walker`

## Requirements
- R1: After reset, `busy`, `done`, `out_valid`, `mem_rd` and `mem_wr` are all 0.
- R2: A start link of 0xFFFFFF causes no memory access and no output. It gives a `done` pulse in the next cycle with `loop_found` = 0.
- R3: A header's bits 31:24 give the payload length N. Its bits 23:0 give the next link. The memory word address of a link is its bits 20:2, and bits 23:21 and 1:0 are ignored. The N words at the header address +1 .. +N are sent on `out_data` in address order.
- R4: A header with a payload length of 0 sends nothing, and the walk continues with its link.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds and the walk does not advance. A word is transferred only in a cycle where both are 1.
- R6: A header whose link is 0xFFFFFF ends the walk after its payload, with `loop_found` = 0.
- R7: Every header read during the walk whose link is not 0xFFFFFF is written back once with bit 23 set and all other bits unchanged. A sentinel header is not written.
- R8: A header whose link already has bit 23 set (and is not 0xFFFFFF) has its payload sent and then ends the walk with `loop_found` = 1.
- R9: The cleanup pass clears bit 23 once for each header tagged in R7. At `done`, every memory word equals its value before the start.
- R10: `busy` rises in the cycle after an accepted start. It stays 1 through cleanup and falls in the cycle where the one-cycle `done` pulse appears. A start while `busy` is 1 is ignored.
- R11: `mem_rd` and `mem_wr` are never both 1, and neither is 1 while `busy` is 0. Each header write goes to the address read two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk; accepted only while idle |
| start_link | input | 24 | Link of the first node |
| busy | output | 1 | Walk or cleanup in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| loop_found | output | 1 | Last walk ended on a tagged node; held until the next start |
| mem_addr | output | 19 | Word address to memory |
| mem_rd | output | 1 | Read request; data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Payload word available |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Sink accepts the word |

## Verification
The walk is driven with several chain patterns:
- an immediate sentinel start, which shows that nothing is touched at all;
- a three-node chain mixing payload lengths of two, zero and three with unused high link bits set, which separates correct address masking, zero-length skipping and ordering from off-by-one payload indexing;
- a single zero-length sentinel node, which shows that a terminal header is read but never rewritten;
- a two-node ring, which tells a loop stop apart from a sentinel stop and shows that the revisited node's payload is sent a second time.

The three-node chain is run a second time with `out_ready` toggling and a spurious start mid-run, to separate correct stalling from dropped or repeated words. Every run ends by comparing the whole memory with its loaded image and counting tag-set and tag-clear writes.

// File: rtl/chain_pkg.sv
package chain_pkg;

   typedef enum logic [3:0] {
      CW_IDLE,
      CW_HREQ,
      CW_HWAIT,
      CW_MARK,
      CW_PAY,
      CW_NEXT,
      CW_CINIT,
      CW_CREQ,
      CW_CWAIT,
      CW_CWR,
      CW_DONE
   } walk_st_e;

   typedef enum logic [1:0] {
      BT_IDLE,
      BT_REQ,
      BT_WAIT,
      BT_OUT
   } beat_st_e;

endpackage

// File: rtl/chain_hdr_split.sv
module chain_hdr_split #(
   parameter int LEN_W   = 8,
   parameter int LINK_W  = 24,
   parameter int BYTE_AW = 21,
   localparam int DATA_W  = LEN_W + LINK_W,
   localparam int WORD_AW = BYTE_AW - 2
) (
   input  logic [DATA_W-1:0]  word_i,
   output logic [LEN_W-1:0]   len_o,
   output logic [WORD_AW-1:0] waddr_o,
   output logic               is_end_o,
   output logic               is_marked_o
);

   logic [LINK_W-1:0] link;

   assign link        = word_i[LINK_W-1:0];
   assign len_o       = word_i[DATA_W-1:LINK_W];
   assign waddr_o     = link[BYTE_AW-1:2];
   assign is_end_o    = (link == {LINK_W{1'b1}});
   assign is_marked_o = link[LINK_W-1];

endmodule

// File: rtl/chain_beat_out.sv
module chain_beat_out
   import chain_pkg::*;
#(
   parameter int LEN_W   = 8,
   parameter int DATA_W  = 32,
   parameter int WORD_AW = 19
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [LEN_W-1:0]   load_len_i,
   input  logic [WORD_AW-1:0] load_waddr_i,
   output logic               active_o,
   output logic               rd_o,
   output logic [WORD_AW-1:0] addr_o,
   input  logic [DATA_W-1:0]  rdata_i,
   output logic               fin_o,
   output logic               out_valid,
   output logic [DATA_W-1:0]  out_data,
   input  logic               out_ready
);

   beat_st_e           st;
   logic [WORD_AW-1:0] ptr;
   logic [LEN_W-1:0]   rem;
   logic [DATA_W-1:0]  word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= BT_IDLE;
         ptr    <= '0;
         rem    <= '0;
         word_q <= '0;
      end else begin
         unique case (st)
            BT_IDLE: begin
               if (load_i) begin
                  ptr <= load_waddr_i + WORD_AW'(1);
                  rem <= load_len_i;
                  st  <= BT_REQ;
               end
            end
            BT_REQ:  st <= BT_WAIT;
            BT_WAIT: begin
               word_q <= rdata_i;
               st     <= BT_OUT;
            end
            BT_OUT: begin
               if (out_ready) begin
                  ptr <= ptr + WORD_AW'(1);
                  rem <= rem - LEN_W'(1);
                  st  <= (rem == LEN_W'(1)) ? BT_IDLE : BT_REQ;
               end
            end
            default: st <= BT_IDLE;
         endcase
      end
   end

   assign active_o  = (st != BT_IDLE);
   assign rd_o      = (st == BT_REQ);
   assign addr_o    = ptr;
   assign out_valid = (st == BT_OUT);
   assign out_data  = word_q;
   assign fin_o     = (st == BT_OUT) && out_ready && (rem == LEN_W'(1));

endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
   import chain_pkg::*;
#(
   parameter int LEN_W   = 8,
   parameter int LINK_W  = 24,
   parameter int BYTE_AW = 21,
   parameter int CNT_W   = 16,
   localparam int DATA_W  = LEN_W + LINK_W,
   localparam int WORD_AW = BYTE_AW - 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [LINK_W-1:0]  start_link_i,
   output logic [DATA_W-1:0]  dec_word_o,
   input  logic [LEN_W-1:0]   f_len_i,
   input  logic [WORD_AW-1:0] f_waddr_i,
   input  logic               f_is_end_i,
   input  logic               f_marked_i,
   output logic               rd_o,
   output logic               wr_o,
   output logic [WORD_AW-1:0] addr_o,
   output logic [DATA_W-1:0]  wdata_o,
   input  logic [DATA_W-1:0]  rdata_i,
   output logic               pay_load_o,
   output logic [LEN_W-1:0]   pay_len_o,
   output logic [WORD_AW-1:0] pay_waddr_o,
   input  logic               pay_fin_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               loop_o
);

   localparam logic [DATA_W-1:0] MARK = DATA_W'(1) << (LINK_W - 1);

   walk_st_e           st;
   logic [WORD_AW-1:0] cur;
   logic [WORD_AW-1:0] first;
   logic [DATA_W-1:0]  hdr_q;
   logic [CNT_W-1:0]   visits;
   logic [CNT_W-1:0]   rem;
   logic               loop_q;

   assign dec_word_o = (st == CW_IDLE) ? {{LEN_W{1'b0}}, start_link_i} : hdr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= CW_IDLE;
         cur    <= '0;
         first  <= '0;
         hdr_q  <= '0;
         visits <= '0;
         rem    <= '0;
         loop_q <= 1'b0;
      end else begin
         unique case (st)
            CW_IDLE: begin
               if (start_i) begin
                  loop_q <= 1'b0;
                  visits <= '0;
                  first  <= f_waddr_i;
                  cur    <= f_waddr_i;
                  st     <= f_is_end_i ? CW_DONE : CW_HREQ;
               end
            end
            CW_HREQ:  st <= CW_HWAIT;
            CW_HWAIT: begin
               hdr_q <= rdata_i;
               st    <= CW_MARK;
            end
            CW_MARK: begin
               if (!f_is_end_i) visits <= visits + CNT_W'(1);
               st <= (f_len_i != '0) ? CW_PAY : CW_NEXT;
            end
            CW_PAY: begin
               if (pay_fin_i) st <= CW_NEXT;
            end
            CW_NEXT: begin
               if (f_is_end_i) begin
                  st <= CW_CINIT;
               end else if (f_marked_i) begin
                  loop_q <= 1'b1;
                  st     <= CW_CINIT;
               end else begin
                  cur <= f_waddr_i;
                  st  <= CW_HREQ;
               end
            end
            CW_CINIT: begin
               rem <= visits;
               cur <= first;
               st  <= (visits == '0) ? CW_DONE : CW_CREQ;
            end
            CW_CREQ:  st <= CW_CWAIT;
            CW_CWAIT: begin
               hdr_q <= rdata_i;
               st    <= CW_CWR;
            end
            CW_CWR: begin
               rem <= rem - CNT_W'(1);
               cur <= f_waddr_i;
               st  <= (rem == CNT_W'(1)) ? CW_DONE : CW_CREQ;
            end
            CW_DONE:  st <= CW_IDLE;
            default:  st <= CW_IDLE;
         endcase
      end
   end

   always_comb begin
      rd_o    = (st == CW_HREQ) || (st == CW_CREQ);
      wr_o    = 1'b0;
      wdata_o = hdr_q;
      if (st == CW_MARK && !f_is_end_i) begin
         wr_o    = 1'b1;
         wdata_o = hdr_q | MARK;
      end else if (st == CW_CWR) begin
         wr_o    = 1'b1;
         wdata_o = hdr_q & ~MARK;
      end
   end

   assign addr_o      = cur;
   assign pay_load_o  = (st == CW_MARK) && (f_len_i != '0);
   assign pay_len_o   = f_len_i;
   assign pay_waddr_o = cur;
   assign busy_o      = (st != CW_IDLE) && (st != CW_DONE);
   assign done_o      = (st == CW_DONE);
   assign loop_o      = loop_q;

endmodule

// File: rtl/chain_walker.sv
module chain_walker #(
   parameter int LEN_W   = 8,
   parameter int LINK_W  = 24,
   parameter int BYTE_AW = 21,
   parameter int CNT_W   = 16,
   localparam int DATA_W  = LEN_W + LINK_W,
   localparam int WORD_AW = BYTE_AW - 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LINK_W-1:0]  start_link,
   output logic               busy,
   output logic               done,
   output logic               loop_found,
   output logic [WORD_AW-1:0] mem_addr,
   output logic               mem_rd,
   output logic               mem_wr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               out_valid,
   output logic [DATA_W-1:0]  out_data,
   input  logic               out_ready
);

   generate
      if (BYTE_AW > LINK_W - 1) begin : g_bad_aw
         $error("address bits must stay below the tag bit");
      end
      if (BYTE_AW < 3) begin : g_bad_small
         $error("byte address width too small");
      end
      if (LEN_W < 1 || CNT_W < 2) begin : g_bad_cnt
         $error("length and visit counter widths too small");
      end
   endgenerate

   logic [DATA_W-1:0]  dec_word;
   logic [LEN_W-1:0]   f_len;
   logic [WORD_AW-1:0] f_waddr;
   logic               f_is_end;
   logic               f_marked;
   logic               c_rd;
   logic               c_wr;
   logic [WORD_AW-1:0] c_addr;
   logic [DATA_W-1:0]  c_wdata;
   logic               p_load;
   logic [LEN_W-1:0]   p_len;
   logic [WORD_AW-1:0] p_waddr;
   logic               p_fin;
   logic               s_active;
   logic               s_rd;
   logic [WORD_AW-1:0] s_addr;

   chain_hdr_split #(
      .LEN_W(LEN_W), .LINK_W(LINK_W), .BYTE_AW(BYTE_AW)
   ) u_split (
      .word_i(dec_word), .len_o(f_len), .waddr_o(f_waddr),
      .is_end_o(f_is_end), .is_marked_o(f_marked)
   );

   chain_ctrl #(
      .LEN_W(LEN_W), .LINK_W(LINK_W), .BYTE_AW(BYTE_AW), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .start_i(start), .start_link_i(start_link),
      .dec_word_o(dec_word),
      .f_len_i(f_len), .f_waddr_i(f_waddr),
      .f_is_end_i(f_is_end), .f_marked_i(f_marked),
      .rd_o(c_rd), .wr_o(c_wr), .addr_o(c_addr), .wdata_o(c_wdata),
      .rdata_i(mem_rdata),
      .pay_load_o(p_load), .pay_len_o(p_len), .pay_waddr_o(p_waddr),
      .pay_fin_i(p_fin),
      .busy_o(busy), .done_o(done), .loop_o(loop_found)
   );

   chain_beat_out #(
      .LEN_W(LEN_W), .DATA_W(DATA_W), .WORD_AW(WORD_AW)
   ) u_beat (
      .clk(clk), .rst_n(rst_n),
      .load_i(p_load), .load_len_i(p_len), .load_waddr_i(p_waddr),
      .active_o(s_active), .rd_o(s_rd), .addr_o(s_addr),
      .rdata_i(mem_rdata), .fin_o(p_fin),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
   );

   assign mem_rd    = c_rd | s_rd;
   assign mem_wr    = c_wr;
   assign mem_addr  = s_active ? s_addr : c_addr;
   assign mem_wdata = c_wdata;

endmodule

// File: rtl/chain_walker_chk.sv
module chain_walker_chk #(
   parameter int DATA_W  = 32,
   parameter int LINK_W  = 24,
   parameter int WORD_AW = 19
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               done,
   input logic [WORD_AW-1:0] mem_addr,
   input logic               mem_rd,
   input logic               mem_wr,
   input logic [DATA_W-1:0]  mem_wdata,
   input logic [DATA_W-1:0]  mem_rdata,
   input logic               out_valid,
   input logic [DATA_W-1:0]  out_data,
   input logic               out_ready
);

   localparam logic [DATA_W-1:0] TAG = DATA_W'(1) << (LINK_W - 1);

   a_r11_no_rw_clash: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_rd && !mem_wr && !out_valid));

   a_r11_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($past(mem_rd, 2) && mem_addr == $past(mem_addr, 2)));

   a_r7_only_tag_changes: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ((mem_wdata & ~TAG) == ($past(mem_rdata) & ~TAG)));

   a_r5_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   a_r3_word_from_mem: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> ($past(mem_rd, 2) && out_data == $past(mem_rdata)));

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

bind chain_walker chain_walker_chk #(
   .DATA_W(DATA_W), .LINK_W(LINK_W), .WORD_AW(WORD_AW)
) u_chk (.*);

// File: tb/sim_chain_walker.sv
module sim_chain_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] start_link = '0;
   logic        busy, done, loop_found;
   logic [18:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        out_valid;
   logic [31:0] out_data;
   logic        out_ready = 1'b1;

   always #10 clk = ~clk;

   chain_walker u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_link(start_link),
      .busy(busy), .done(done), .loop_found(loop_found),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
   );

   logic [31:0] mem    [256];
   logic [31:0] shadow [256];
   logic [31:0] got    [32];
   logic        ld_we = 1'b0;
   logic [7:0]  ld_a  = '0;
   logic [31:0] ld_d  = '0;
   logic        clr = 1'b0;
   int          n_set, n_clr, n_acc, n_got;
   int          checks = 0;
   int          errors = 0;

   always_ff @(posedge clk) begin
      if (ld_we) begin
         mem[ld_a] <= ld_d;
      end else begin
         if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
         if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
      end
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         n_set <= 0; n_clr <= 0; n_acc <= 0; n_got <= 0;
      end else begin
         if (mem_rd || mem_wr) n_acc <= n_acc + 1;
         if (mem_wr && mem_wdata[23])  n_set <= n_set + 1;
         if (mem_wr && !mem_wdata[23]) n_clr <= n_clr + 1;
         if (out_valid && out_ready) begin
            got[n_got[4:0]] <= out_data;
            n_got <= n_got + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic poke(input int a, input logic [31:0] d);
      @(negedge clk);
      ld_we = 1'b1; ld_a = 8'(a); ld_d = d;
      shadow[a] = d;
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) begin
         mem[i] = 32'h0; shadow[i] = 32'h0;
      end
   endtask

   task automatic zero_counts();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   int  dones;
   bit  loop_seen;

   task automatic run_walk(input logic [23:0] link, input bit stall, input bit extra, input bit expect_busy);
      dones = 0;
      loop_seen = 1'b0;
      zero_counts();
      @(negedge clk);
      start = 1'b1; start_link = link;
      @(negedge clk);
      start = 1'b0;
      if (expect_busy) chk(busy == 1'b1, "R10 busy after start", busy, 1);
      if (done) begin dones++; loop_seen = loop_found; end
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (stall) out_ready = ~out_ready; else out_ready = 1'b1;
         if (extra && i == 6) begin start = 1'b1; start_link = 24'hFFFFFF; end
         else start = 1'b0;
         if (done) begin dones++; loop_seen = loop_found; end
         if (dones > 0 && i > 10 && !busy) break;
      end
      start = 1'b0;
      out_ready = 1'b1;
      repeat (4) begin
         @(negedge clk);
         if (done) dones++;
      end
   endtask

   function automatic bit mem_same();
      for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic check_words(input string req, input int n, input logic [31:0] e [8]);
      chk(n_got == n, {req, " word count"}, n_got, n);
      for (int i = 0; i < n && i < n_got; i++)
         chk(got[i] == e[i], {req, " word value"}, got[i], e[i]);
   endtask

   task automatic t_reset();
      chk(!busy && !done && !out_valid && !mem_rd && !mem_wr,
          "R1 reset outputs", {busy, done, out_valid, mem_rd, mem_wr}, 0);
   endtask

   task automatic t_sentinel_start();
      zero_counts();
      @(negedge clk);
      start = 1'b1; start_link = 24'hFFFFFF;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1 && busy == 1'b0, "R2 done next cycle", {done, busy}, 2'b10);
      chk(loop_found == 1'b0, "R2 no loop", loop_found, 0);
      repeat (3) @(negedge clk);
      chk(n_acc == 0 && n_got == 0, "R2 no access or output", n_acc + n_got, 0);
   endtask

   task automatic load_chain();
      clear_mem();
      poke(8'h10, 32'h0220_0080);
      poke(8'h11, 32'hA000_0001);
      poke(8'h12, 32'hA000_0002);
      poke(8'h20, 32'h0000_00C0);
      poke(8'h30, 32'h03FF_FFFF);
      poke(8'h31, 32'hB000_0001);
      poke(8'h32, 32'hB000_0002);
      poke(8'h33, 32'hB000_0003);
   endtask

   task automatic t_chain(input bit stall);
      logic [31:0] e [8];
      string tag;
      tag = stall ? "R5" : "R3";
      e = '{32'hA000_0001, 32'hA000_0002, 32'hB000_0001, 32'hB000_0002,
            32'hB000_0003, 0, 0, 0};
      load_chain();
      run_walk(24'h400040, stall, stall, 1'b1);
      check_words(tag, 5, e);
      chk(dones == 1, "R10 single done", dones, 1);
      chk(loop_seen == 1'b0, "R6 sentinel end", loop_seen, 0);
      chk(n_set == 2, "R7 tags set (R4 zero-length node walked)", n_set, 2);
      chk(n_clr == 2, "R9 tags cleared", n_clr, 2);
      chk(mem_same(), "R9 memory restored", 0, 1);
   endtask

   task automatic t_ring();
      logic [31:0] e [8];
      e = '{32'hC000_0001, 32'hD000_0001, 32'hD000_0002, 32'hC000_0001, 0, 0, 0, 0};
      clear_mem();
      poke(8'h50, 32'h0100_0180);
      poke(8'h51, 32'hC000_0001);
      poke(8'h60, 32'h0200_0140);
      poke(8'h61, 32'hD000_0001);
      poke(8'h62, 32'hD000_0002);
      run_walk(24'h000140, 1'b0, 1'b0, 1'b1);
      check_words("R8", 4, e);
      chk(loop_seen == 1'b1, "R8 loop reported", loop_seen, 1);
      chk(n_set == 3 && n_clr == 3, "R9 ring tag writes", n_set * 16 + n_clr, 8'h33);
      chk(mem_same(), "R9 ring memory restored", 0, 1);
   endtask

   task automatic t_lone_terminal();
      clear_mem();
      poke(8'h70, 32'h00FF_FFFF);
      run_walk(24'h0001C0, 1'b0, 1'b0, 1'b1);
      chk(n_got == 0, "R4 zero length sends nothing", n_got, 0);
      chk(n_set == 0 && n_clr == 0, "R7 sentinel header not written", n_set + n_clr, 0);
      chk(n_acc == 1, "R7 one header read", n_acc, 1);
      chk(loop_seen == 1'b0 && mem_same(), "R6 lone terminal", loop_seen, 0);
   endtask

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_sentinel_start();
      t_chain(1'b0);
      t_chain(1'b1);
      t_ring();
      t_lone_terminal();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule